// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block tells a memory controller when an asynchronous DRAM with a fixed number of rows needs refreshing. The DRAM uses CAS-before-RAS refresh, so the device steps its own internal row counter. The sequencer therefore never supplies a row address. It only raises a request and waits for the controller to acknowledge each completed refresh cycle. The block runs from a system clock. A frequency parameter turns the microsecond timing figures into clock-cycle counts, and each count is rounded down.

After reset the block stays quiet through a power-up pause. It then asks for a burst of wake-up refreshes back to back, and it raises `ready` only after the controller has acknowledged the last refresh of that burst. In normal running it schedules one refresh per interval. The interval is the refresh period divided by the row count, which is about 15.6 µs for 512 rows in 8 ms.

Refreshes that the controller has not yet served are counted as pending, up to a small limit. Suppose one more interval expires while the count is already at that limit and no acknowledge arrives in the same cycle. The refresh window is then taken as broken. The block pulses `overrun`, drops `ready` and runs the whole wake-up burst again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, and for PAUSE_CYC = floor(CLK_HZ*PAUSE_US/1e6) clock cycles after reset is released, `ref_req`, `ready` and `overrun` are all low.
- R2: Once the pause ends, `ref_req` is high in every cycle until WAKE_N acknowledges have been counted, and `ready` stays low during that time.
- R3: `ready` goes high in the cycle after the cycle in which the WAKE_N-th wake-up acknowledge is sampled, and it stays high until an overrun occurs.
- R4: While ready, a refresh is scheduled every IVL_CYC = floor(CLK_HZ*PERIOD_US/(1e6*ROWS)) cycles. The first one is scheduled in the IVL_CYC-th ready cycle. A scheduled refresh shows on `ref_req` from the next cycle.
- R5: While ready, `ref_req` is high exactly when the pending count is non-zero. Each cycle in which `ref_ack` and `ref_req` are both high removes one pending refresh.
- R6: The pending count may reach PEND_MAX. If a refresh is scheduled in the same cycle as a counted acknowledge, the count does not change and no overrun occurs, even when the count is at PEND_MAX.
- R7: `ref_ack` has no effect in any cycle where `ref_req` is low, and that includes the power-up pause.
- R8: If a refresh is scheduled while the pending count equals PEND_MAX and no acknowledge is counted in that cycle, then in the next cycle `overrun` is high for exactly one cycle and `ready` is low. The pending count is discarded, and the wake-up burst of R2 and R3 runs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; its frequency is the CLK_HZ parameter |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ack | input | 1 | Controller reports that one CAS-before-RAS refresh has completed |
| ref_req | output | 1 | A refresh cycle is wanted |
| ready | output | 1 | Wake-up is complete and normal accesses are allowed |
| overrun | output | 1 | One-cycle pulse when the refresh window has been violated |

## Verification
The scheduling of a new refresh and the acceptance of an acknowledge can land in the same clock cycle. The bench provokes this on purpose. It first withholds acknowledges until the pending count reaches its limit. It then acknowledges only in the cycles where its own interval model expects the next refresh to be scheduled. The expected result is that `ref_req` stays high, the count holds at the limit, and `overrun` never pulses. Next the bench withholds one more acknowledge at the limit. That tick must produce exactly one `overrun` pulse, followed by a fresh wake-up burst that completes only after eight further acknowledges.

// File: rtl/drs_pkg.sv
package drs_pkg;
   typedef enum logic [1:0] {
      ST_PAUSE = 2'd0,
      ST_WAKE  = 2'd1,
      ST_RUN   = 2'd2
   } drs_state_e;
endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
   parameter longint unsigned CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYC - 1);

   logic [CW-1:0] cnt;

   if (CYC < 2) begin : g_bad_cyc
      $error("drs_interval_timer: CYC must be at least 2");
   end

   assign tick = en && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!en)   cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R4
endmodule

// File: rtl/drs_pend_ctr.sv
module drs_pend_ctr #(
   parameter int PEND_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec,
   output logic nz,
   output logic at_max
);
   if (PEND_MAX < 1) begin : g_bad_max
      $error("drs_pend_ctr: PEND_MAX must be at least 1");
   end

   if (PEND_MAX == 1) begin : g_flag
      logic flag;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag <= 1'b0;
         else if (clr)      flag <= 1'b0;
         else if (inc)      flag <= 1'b1;
         else if (dec)      flag <= 1'b0;
      end
      assign nz     = flag;
      assign at_max = flag;
   end else begin : g_count
      localparam int PW = $clog2(PEND_MAX + 1);
      localparam logic [PW-1:0] TOP = PW'(PEND_MAX);
      logic [PW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt <= '0;
         else if (clr)            cnt <= '0;
         else if (inc && !dec)    cnt <= cnt + 1'b1;
         else if (dec && !inc)    cnt <= cnt - 1'b1;
      end
      assign nz     = (cnt != '0);
      assign at_max = (cnt == TOP);

      AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= TOP); // R6
   end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import drs_pkg::*;
#(
   parameter longint unsigned CLK_HZ    = 100_000_000,
   parameter longint unsigned PAUSE_US  = 100_000,
   parameter longint unsigned PERIOD_US = 8_000,
   parameter int              ROWS      = 512,
   parameter int              WAKE_N    = 8,
   parameter int              PEND_MAX  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_ack,
   output logic ref_req,
   output logic ready,
   output logic overrun
);
   localparam longint unsigned PAUSE_CYC = (CLK_HZ * PAUSE_US) / 64'd1_000_000;
   localparam longint unsigned IVL_CYC   =
      (CLK_HZ * PERIOD_US) / (64'd1_000_000 * longint'(ROWS));
   localparam int WW = $clog2(WAKE_N + 1);
   localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE_N);

   if (WAKE_N < 1) begin : g_bad_wake
      $error("dram_refresh_seq: WAKE_N must be at least 1");
   end
   if (ROWS < 1) begin : g_bad_rows
      $error("dram_refresh_seq: ROWS must be at least 1");
   end

   drs_state_e    state;
   logic [WW-1:0] wake_left;
   logic          pause_done;
   logic          run_tick;
   logic          pend_nz;
   logic          pend_full;
   logic          ack_taken;
   logic          miss;
   logic          ovr_q;

   drs_interval_timer #(.CYC(PAUSE_CYC)) u_pause (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (state == ST_PAUSE),
      .tick  (pause_done)
   );

   drs_interval_timer #(.CYC(IVL_CYC)) u_ivl (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (state == ST_RUN),
      .tick  (run_tick)
   );

   assign ack_taken = ref_ack && ref_req;
   assign miss      = (state == ST_RUN) && run_tick && pend_full && !ack_taken;

   drs_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    ((state != ST_RUN) || miss),
      .inc    (run_tick),
      .dec    ((state == ST_RUN) && ack_taken),
      .nz     (pend_nz),
      .at_max (pend_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_PAUSE;
         wake_left <= '0;
         ovr_q     <= 1'b0;
      end else begin
         ovr_q <= miss;
         unique case (state)
            ST_PAUSE: begin
               if (pause_done) begin
                  state     <= ST_WAKE;
                  wake_left <= WAKE_LOAD;
               end
            end
            ST_WAKE: begin
               if (ack_taken) begin
                  if (wake_left == WW'(1)) state <= ST_RUN;
                  wake_left <= wake_left - 1'b1;
               end
            end
            ST_RUN: begin
               if (miss) begin
                  state     <= ST_WAKE;
                  wake_left <= WAKE_LOAD;
               end
            end
            default: state <= ST_PAUSE;
         endcase
      end
   end

   assign ref_req = (state == ST_WAKE) || ((state == ST_RUN) && pend_nz);
   assign ready   = (state == ST_RUN);
   assign overrun = ovr_q;

   AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(ref_ack && ref_req)); // R3
   AST_OVR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> (!ready && ref_req)); // R8
   AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> !overrun); // R8
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_ack) |=> ref_req); // R5
   AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PAUSE) |-> (!ref_req && !ready && !overrun)); // R1
endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
   localparam longint unsigned T_CLK_HZ = 1_000_000;
   localparam longint unsigned T_PAUSE  = 40;
   localparam int              P_CYC    = 40;   // floor(1e6*40/1e6)
   localparam int              IV       = 15;   // floor(1e6*8000/(1e6*512))
   localparam int              W_N      = 8;
   localparam int              PMAX     = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_ack = 1'b0;
   logic ref_req, ready, overrun;

   always #2.5 clk = ~clk;

   dram_refresh_seq #(
      .CLK_HZ(T_CLK_HZ), .PAUSE_US(T_PAUSE), .PERIOD_US(8000),
      .ROWS(512), .WAKE_N(W_N), .PEND_MAX(PMAX)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack),
      .ref_req(ref_req), .ready(ready), .overrun(overrun)
   );

   int checks = 0;
   int errors = 0;
   int ovr_seen = 0;
   bit done = 1'b0;

   // reference model state (built from R1..R8)
   int m_st = 0;     // 0 pause, 1 wake, 2 run
   int m_pc = 0;
   int m_wl = 0;
   int m_pend = 0;
   int m_tc = 0;
   bit m_ovr = 1'b0;

   logic [2:0] exp_q[$];   // {ready, ref_req, overrun}
   string      tag_q[$];

   // driver for ack: 0 never, 1 always, 3 after 3 cycles of request, 5 only on model tick
   int mode = 0;
   int rq_age = 0;

   task automatic push_exp(input string tg);
      exp_q.push_back({m_st == 2, (m_st == 1) || (m_st == 2 && m_pend != 0), m_ovr});
      tag_q.push_back(tg);
   endtask

   always @(posedge clk) begin
      string tg;
      bit tk, ak;
      if (!rst_n) begin
         m_st = 0; m_pc = 0; m_wl = 0; m_pend = 0; m_tc = 0; m_ovr = 0;
         tg = "R1";
      end else begin
         m_ovr = 0;
         case (m_st)
            0: begin
               tg = ref_ack ? "R7" : "R1";
               if (m_pc == P_CYC - 1) begin m_st = 1; m_wl = W_N; m_pc = 0; end
               else m_pc++;
            end
            1: begin
               tg = "R2";
               if (ref_ack) begin
                  if (m_wl == 1) begin m_st = 2; m_tc = 0; m_pend = 0; tg = "R3"; end
                  m_wl--;
               end
            end
            default: begin
               tk = (m_tc == IV - 1);
               ak = ref_ack && (m_pend != 0);
               m_tc = tk ? 0 : m_tc + 1;
               tg = tk ? "R4" : "R5";
               if (ref_ack && m_pend == 0) tg = "R7";
               if (tk && ak) tg = "R6";
               if (tk && !ak && m_pend == PMAX) begin
                  m_ovr = 1; m_st = 1; m_wl = W_N; m_pend = 0; tg = "R8";
               end else begin
                  m_pend = m_pend + int'(tk) - int'(ak);
               end
            end
         endcase
      end
      push_exp(tg);
   end

   // monitor: pops one expectation per cycle and compares at the falling edge
   always @(negedge clk) begin
      logic [2:0] e;
      string tg;
      if (exp_q.size() != 0 && !done) begin
         e = exp_q.pop_front();
         tg = tag_q.pop_front();
         checks++;
         if (ready !== e[2]) begin
            errors++;
            $display("FAIL %s: ready=%0b expected %0b at %0t", tg, ready, e[2], $time);
         end
         if (ref_req !== e[1]) begin
            errors++;
            $display("FAIL %s: ref_req=%0b expected %0b at %0t", tg, ref_req, e[1], $time);
         end
         if (overrun !== e[0]) begin
            errors++;
            $display("FAIL %s: overrun=%0b expected %0b at %0t", tg, overrun, e[0], $time);
         end
         if (overrun === 1'b1) ovr_seen++;
      end
   end

   // ack driver
   always @(negedge clk) begin
      rq_age = (ref_req === 1'b1) ? rq_age + 1 : 0;
      case (mode)
         1: ref_ack <= 1'b1;
         3: ref_ack <= (rq_age >= 3);
         5: ref_ack <= (m_st == 2) && (m_tc == IV - 1);
         default: ref_ack <= 1'b0;
      endcase
   end

   task automatic check_val(input string tg, input int act, input int expv, input string what);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: %s=%0d expected %0d", tg, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(5 * 60000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check_val("R1", int'(ref_req) + int'(ready) + int'(overrun), 0, "outputs_in_reset");
      mode = 1;                       // R7: ack during pause must be ignored
      @(negedge clk);
      rst_n = 1'b1;
      repeat (P_CYC + W_N + 4) @(negedge clk);
      check_val("R3", int'(ready), 1, "ready_after_wake");
      repeat (100) @(negedge clk);    // R4 R5 with prompt acks
      mode = 3;
      repeat (100) @(negedge clk);    // R5 with delayed acks
      mode = 0;
      repeat (3 * IV + 2) @(negedge clk);
      check_val("R6", m_pend, PMAX, "model_pending");
      mode = 5;                       // R6: tick and ack in the same cycle at the limit
      repeat (4 * IV) @(negedge clk);
      check_val("R6", ovr_seen, 0, "overrun_pulses");
      check_val("R6", int'(ref_req), 1, "ref_req_at_limit");
      mode = 0;                       // R8: miss at the limit
      repeat (IV + 3) @(negedge clk);
      check_val("R8", ovr_seen, 1, "overrun_pulses");
      check_val("R8", int'(ready), 0, "ready_after_overrun");
      repeat (5) @(negedge clk);
      check_val("R2", int'(ref_req), 1, "wake_req_stalled");
      mode = 1;                       // R2 R3: repeated wake burst completes
      repeat (W_N + 3) @(negedge clk);
      check_val("R3", int'(ready), 1, "ready_after_rewake");
      repeat (60) @(negedge clk);
      check_val("R8", ovr_seen, 1, "overrun_pulses_final");
      finish_run();
   end
endmodule